// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Meter

This block measures the rate of one on-chip clock by counting its rising edges while a gate derived from a reference clock is open for a fixed number of reference cycles. The clock under test comes from one of two banks of 64 inputs. In the generator bank an input goes straight to the counter. In the analog-test bank it first passes through a divide-by-two stage. Software converts the count to a frequency afterwards; the meter itself reports only the raw edge count.

Four word registers are reached through a plain write strobe, a two-bit word address, and a combinational read port. Word 0 holds the source selection, word 1 holds the bank choice, word 2 is the control and status word, and word 3 returns the count. A run begins with two writes: one sets the enable, and a second sets both the enable and the go bit. Software then polls the go bit until it reads zero and reads the count. The gate, the stop request and the stop acknowledge each cross between the reference and measured clock domains through two-flop synchronizers.

Top module: `fm_freq_meter`

## Requirements
- R1: After reset, words 0, 1, 2 and 3 all read as zero.
- R2: When word 1 bit 24 is 0 and word 0 bit 0 is 1, the meter counts `gen_clk_i[id]`, where id is word 0 bits [13:8].
- R3: When word 1 bit 24 is 0 and word 0 bit 0 is 0, no clock reaches the counter. A started run never completes, and word 2 bit 4 stays 1 until the run is cancelled.
- R4: A write of word 2 with bit 12 = 1 arms the meter, and bit 12 then reads back as 1. A write with bits 12 and 4 both set starts a run only if bit 12 was already 1 before that write.
- R5: Word 2 bit 4 reads 1 from the cycle after an accepted start until the new count is available in word 3, and then reads 0.
- R6: The count equals the number of rising edges of the selected clock during a 1024-reference-cycle gate, within ±2. It appears in word 3 bits [15:0], and bits [31:16] read as zero.
- R7: When word 1 bit 24 is 1, the meter counts `ana_clk_i[id]` after a divide-by-two, where id is word 0 bits [21:16].
- R8: When the clock under test would give more than 65535 edges in the gate, the count stops at 0xFFFF and does not wrap.
- R9: A start request made while word 2 bit 4 reads 1 is ignored. The running measurement ends on its original schedule, with its original count.
- R10: A write of word 2 with bit 12 = 0 clears the enable and cancels a running measurement. After that, word 2 reads 0.
- R11: Word 3 keeps its previous count until a new measurement completes, including across a cancelled run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock; it times the gate and runs the register port |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| gen_clk_i | input | 64 | Generator-bank clocks under test |
| ana_clk_i | input | 64 | Analog-test-bank clocks under test, divided by two before counting |
| reg_we_i | input | 1 | Register write strobe, sampled on clk_ref_i |
| reg_addr_i | input | 2 | Word address: 0 source, 1 bank, 2 control, 3 result |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |

## Verification
The hardest state to reach from the ports is a measurement that can never finish. In that state the gate opens into a domain whose clock is held low, so the acknowledge never returns and the go bit stays high. The bench creates it by clearing the generator enable bit before it starts a run. It then checks that the go bit is still set several windows later, cancels the run, and reads back the count from the previous run. A second awkward case is a restart issued halfway through a window. The bench drives it on a timed cycle and then checks that the go bit falls within the time of one window, not one and a half.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_SRC    = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_BANK   = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd2;
  localparam logic [REG_AW-1:0] ADDR_RESULT = 2'd3;

  localparam int unsigned GEN_EN_BIT  = 0;
  localparam int unsigned GEN_ID_LSB  = 8;
  localparam int unsigned ANA_ID_LSB  = 16;
  localparam int unsigned BANK_BIT    = 24;
  localparam int unsigned CTRL_EN_BIT = 12;
  localparam int unsigned CTRL_GO_BIT = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WIN   = 2'd1,
    ST_DRAIN = 2'd2
  } meas_state_e;
endpackage

// File: rtl/fm_sync2.sv
`timescale 1ns/1ps
module fm_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= '0;
    else          stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fm_regs.sv
`timescale 1ns/1ps
module fm_regs
  import fm_pkg::*;
#(
  parameter int unsigned SRC_ID_W = 6,
  parameter int unsigned CNT_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                busy_i,
  input  logic [CNT_W-1:0]    result_i,
  output logic [SRC_ID_W-1:0] gen_id_o,
  output logic [SRC_ID_W-1:0] ana_id_o,
  output logic                gen_en_o,
  output logic                bank_o,
  output logic                armed_o,
  output logic                go_o,
  output logic                abort_o
);
  logic [31:0] src_q, src_d;
  logic [31:0] bank_q, bank_d;
  logic        en_q, en_d;
  logic        src_we, bank_we, ctrl_we;

  always_comb begin
    src_we  = we_i && (addr_i == ADDR_SRC);
    bank_we = we_i && (addr_i == ADDR_BANK);
    ctrl_we = we_i && (addr_i == ADDR_CTRL);
    src_d   = src_we  ? wdata_i : src_q;
    bank_d  = bank_we ? wdata_i : bank_q;
    en_d    = ctrl_we ? wdata_i[CTRL_EN_BIT] : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      src_q  <= '0;
      bank_q <= '0;
      en_q   <= 1'b0;
    end else begin
      src_q  <= src_d;
      bank_q <= bank_d;
      en_q   <= en_d;
    end
  end

  assign go_o     = ctrl_we && wdata_i[CTRL_EN_BIT] && wdata_i[CTRL_GO_BIT];
  assign abort_o  = ctrl_we && !wdata_i[CTRL_EN_BIT];
  assign armed_o  = en_q;
  assign gen_id_o = src_q[GEN_ID_LSB +: SRC_ID_W];
  assign ana_id_o = src_q[ANA_ID_LSB +: SRC_ID_W];
  assign gen_en_o = src_q[GEN_EN_BIT];
  assign bank_o   = bank_q[BANK_BIT];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_SRC:  rdata_o = src_q;
      ADDR_BANK: rdata_o = bank_q;
      ADDR_CTRL: begin
        rdata_o[CTRL_EN_BIT] = en_q;
        rdata_o[CTRL_GO_BIT] = busy_i;
      end
      default:   rdata_o = 32'(result_i);
    endcase
  end
endmodule

// File: rtl/fm_src_mux.sv
`timescale 1ns/1ps
module fm_src_mux #(
  parameter  int unsigned SRC_ID_W = 6,
  localparam int unsigned NUM_SRC  = 1 << SRC_ID_W
) (
  input  logic                rst_n_i,
  input  logic [NUM_SRC-1:0]  gen_clk_i,
  input  logic [NUM_SRC-1:0]  ana_clk_i,
  input  logic [SRC_ID_W-1:0] gen_id_i,
  input  logic [SRC_ID_W-1:0] ana_id_i,
  input  logic                gen_en_i,
  input  logic                bank_i,
  output logic                meas_clk_o
);
  logic gen_pick, ana_pick;
  logic half_q, half_d;

  assign gen_pick = gen_clk_i[gen_id_i] & gen_en_i;
  assign ana_pick = ana_clk_i[ana_id_i];

  always_comb half_d = ~half_q;

  // toggle stage: the analog bank is counted at half rate
  always_ff @(posedge ana_pick or negedge rst_n_i) begin
    if (!rst_n_i) half_q <= 1'b0;
    else          half_q <= half_d;
  end

  assign meas_clk_o = bank_i ? half_q : gen_pick;
endmodule

// File: rtl/fm_edge_cnt.sv
`timescale 1ns/1ps
module fm_edge_cnt #(
  parameter  int unsigned CNT_W   = 16,
  localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
  input  logic             meas_clk_i,
  input  logic             rst_n_i,
  input  logic             gate_i,
  output logic             ack_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             rst_t_n;
  logic             gate_s;
  logic             gate_d_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  fm_sync2 u_rst_sync (
    .clk_i(meas_clk_i), .rst_n_i(rst_n_i), .d_i(1'b1), .q_o(rst_t_n)
  );
  fm_sync2 u_gate_sync (
    .clk_i(meas_clk_i), .rst_n_i(rst_t_n), .d_i(gate_i), .q_o(gate_s)
  );

  always_comb begin
    cnt_d = cnt_q;
    if (gate_s && !gate_d_q)            cnt_d = CNT_W'(1);
    else if (gate_s && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge meas_clk_i or negedge rst_t_n) begin
    if (!rst_t_n) begin
      gate_d_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      gate_d_q <= gate_s;
      cnt_q    <= cnt_d;
    end
  end

  assign ack_o = gate_d_q;
  assign cnt_o = cnt_q;

  AST_CNT_SATURATES: assert property (@(posedge meas_clk_i) disable iff (!rst_t_n)
    (gate_s && gate_d_q && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R8
  AST_CNT_FROZEN_CLOSED: assert property (@(posedge meas_clk_i) disable iff (!rst_t_n)
    (!gate_s) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/fm_gate_ctrl.sv
`timescale 1ns/1ps
module fm_gate_ctrl
  import fm_pkg::*;
#(
  parameter  int unsigned WINDOW = 1024,
  parameter  int unsigned CNT_W  = 16,
  localparam int unsigned WIN_W  = $clog2(WINDOW)
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             go_i,
  input  logic             armed_i,
  input  logic             abort_i,
  input  logic             ack_t_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             gate_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);

  meas_state_e      state_q, state_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             seen_q, seen_d;
  logic             gate_q, gate_d;
  logic [CNT_W-1:0] result_q, result_d;
  logic             ack_s;
  logic             start;
  logic             capture;

  fm_sync2 u_ack_sync (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .d_i(ack_t_i), .q_o(ack_s)
  );

  assign busy_o = (state_q != ST_IDLE) || ack_s;
  assign start  = go_i && armed_i && !busy_o;

  always_comb begin
    state_d  = state_q;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_WIN;
      ST_WIN:   if (win_q == WIN_LAST) state_d = ST_DRAIN;
      ST_DRAIN: if (seen_q && !ack_s) begin
        state_d = ST_IDLE;
        capture = 1'b1;
      end
      default:  state_d = ST_IDLE;
    endcase
    if (abort_i) begin
      state_d = ST_IDLE;
      capture = 1'b0;
    end
    win_d    = (state_q == ST_WIN) ? win_q + WIN_W'(1) : '0;
    seen_d   = (state_q == ST_IDLE) ? 1'b0 : (seen_q || ack_s);
    gate_d   = (state_d == ST_WIN);
    result_d = capture ? cnt_i : result_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q  <= ST_IDLE;
      win_q    <= '0;
      seen_q   <= 1'b0;
      gate_q   <= 1'b0;
      result_q <= '0;
    end else begin
      state_q  <= state_d;
      win_q    <= win_d;
      seen_q   <= seen_d;
      gate_q   <= gate_d;
      result_q <= result_d;
    end
  end

  assign gate_o   = gate_q;
  assign result_o = result_q;

  AST_WINDOW_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($fell(gate_q) && !$past(abort_i)) |-> ($past(win_q) == WIN_LAST)); // R6
  AST_GO_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == ST_WIN && go_i && !abort_i && win_q != WIN_LAST)
      |=> (state_q == ST_WIN && win_q == $past(win_q) + WIN_W'(1))); // R9
  AST_ABORT_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    abort_i |=> (state_q == ST_IDLE && !gate_q)); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q != ST_DRAIN) |=> $stable(result_q)); // R11
endmodule

// File: rtl/fm_freq_meter.sv
`timescale 1ns/1ps
module fm_freq_meter
  import fm_pkg::*;
#(
  parameter  int unsigned SRC_ID_W = 6,
  parameter  int unsigned WINDOW   = 1024,
  parameter  int unsigned CNT_W    = 16,
  localparam int unsigned NUM_SRC  = 1 << SRC_ID_W
) (
  input  logic               clk_ref_i,
  input  logic               rst_n_i,
  input  logic [NUM_SRC-1:0] gen_clk_i,
  input  logic [NUM_SRC-1:0] ana_clk_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o
);
  logic                rst_ref_n;
  logic [SRC_ID_W-1:0] gen_id, ana_id;
  logic                gen_en, bank, armed, go, abort;
  logic                busy, gate, ack_t, meas_clk;
  logic [CNT_W-1:0]    cnt_t, result;

  fm_sync2 u_rst_ref (
    .clk_i(clk_ref_i), .rst_n_i(rst_n_i), .d_i(1'b1), .q_o(rst_ref_n)
  );

  fm_regs #(.SRC_ID_W(SRC_ID_W), .CNT_W(CNT_W)) u_regs (
    .clk_i(clk_ref_i), .rst_n_i(rst_ref_n),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .result_i(result),
    .gen_id_o(gen_id), .ana_id_o(ana_id), .gen_en_o(gen_en), .bank_o(bank),
    .armed_o(armed), .go_o(go), .abort_o(abort)
  );

  fm_src_mux #(.SRC_ID_W(SRC_ID_W)) u_mux (
    .rst_n_i(rst_n_i), .gen_clk_i(gen_clk_i), .ana_clk_i(ana_clk_i),
    .gen_id_i(gen_id), .ana_id_i(ana_id), .gen_en_i(gen_en), .bank_i(bank),
    .meas_clk_o(meas_clk)
  );

  fm_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
    .meas_clk_i(meas_clk), .rst_n_i(rst_n_i), .gate_i(gate),
    .ack_o(ack_t), .cnt_o(cnt_t)
  );

  fm_gate_ctrl #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_ctrl (
    .clk_i(clk_ref_i), .rst_n_i(rst_ref_n),
    .go_i(go), .armed_i(armed), .abort_i(abort),
    .ack_t_i(ack_t), .cnt_i(cnt_t),
    .gate_o(gate), .busy_o(busy), .result_o(result)
  );

  AST_GATE_NEEDS_ENABLE: assert property (@(posedge clk_ref_i) disable iff (!rst_ref_n)
    gate |-> armed); // R4
endmodule

// File: tb/fm_freq_meter_tb_top.sv
`timescale 1ns/1ps
module fm_freq_meter_tb_top;
  localparam real         REF_PERIOD = 20.0;
  localparam int unsigned WIN        = 1024;
  localparam logic [1:0]  A_SRC = 2'd0, A_BANK = 2'd1, A_CTRL = 2'd2, A_RES = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] gen_clk, ana_clk;
  logic        ck_a = 1'b0, ck_b = 1'b0, ck_f = 1'b0, ck_an = 1'b0;
  logic        fast_on = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int    exp_q[$];
  int    tol_q[$];
  string tag_q[$];
  event  done_ev, ack_ev;

  always #(REF_PERIOD/2.0) clk = ~clk;
  always #4  ck_a  = ~ck_a;    // period 8
  always #15 ck_b  = ~ck_b;    // period 30
  always #2  ck_an = ~ck_an;   // period 4
  initial forever begin
    wait (fast_on);
    #0.125 ck_f = ~ck_f;       // period 0.25
  end

  always_comb begin
    gen_clk     = '0;
    gen_clk[3]  = ck_a;
    gen_clk[9]  = ck_b;
    gen_clk[40] = ck_f;
    ana_clk     = '0;
    ana_clk[5]  = ck_an;
  end

  fm_freq_meter dut_i (
    .clk_ref_i(clk), .rst_n_i(rst_n), .gen_clk_i(gen_clk), .ana_clk_i(ana_clk),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata)
  );

  function automatic int edges(input real period);
    real n;
    n = (WIN * REF_PERIOD) / period;
    if (n > 65535.0) return 65535;
    return int'($floor(n));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    bit idle = 1'b0;
    for (int i = 0; i < 4000 && !idle; i++) begin
      rd(A_CTRL, v);
      idle = !v[4];
    end
    chk(idle, {tag, " go bit never cleared"}, 1, 0);
  endtask

  task automatic measure(input int expv, input int tol, input string tag);
    exp_q.push_back(expv);
    tol_q.push_back(tol);
    tag_q.push_back(tag);
    wr(A_CTRL, 32'h0000_1000);
    wr(A_CTRL, 32'h0000_1010);
    wait_idle(tag);
    -> done_ev;
    @(ack_ev);
  endtask

  initial begin : monitor
    logic [31:0] v;
    int e, t, diff;
    string tg;
    forever begin
      @(done_ev);
      rd(A_RES, v);
      e  = exp_q.pop_front();
      t  = tol_q.pop_front();
      tg = tag_q.pop_front();
      diff = int'(v[15:0]) - e;
      if (diff < 0) diff = -diff;
      chk(diff <= t && v[31:16] == 16'h0, tg, v, e);
      -> ack_ev;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] v, kept;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset values
    rd(A_SRC, v);  chk(v == 0, "R1 source word", v, 0);
    rd(A_BANK, v); chk(v == 0, "R1 bank word", v, 0);
    rd(A_CTRL, v); chk(v == 0, "R1 control word", v, 0);
    rd(A_RES, v);  chk(v == 0, "R1 result word", v, 0);

    // R4 go without prior enable must not start
    wr(A_SRC, (32'd3 << 8) | 32'd1);
    wr(A_CTRL, 32'h0000_1010);
    rd(A_CTRL, v); chk(v == 32'h1000, "R4 go without arm", v, 32'h1000);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk(v == 0, "R10 disable from idle", v, 0);

    // R4 arm readback
    wr(A_CTRL, 32'h0000_1000);
    rd(A_CTRL, v); chk(v == 32'h1000, "R4 arm readback", v, 32'h1000);
    wr(A_CTRL, 32'h0);

    // R2 R6 generator bank, two rates
    measure(edges(8.0), 2, "R2 R6 gen source 3");
    wr(A_SRC, (32'd9 << 8) | 32'd1);
    measure(edges(30.0), 2, "R2 R6 gen source 9");

    // R7 analog bank, divided by two
    wr(A_SRC, 32'd5 << 16);
    wr(A_BANK, 32'd1 << 24);
    measure(edges(8.0), 2, "R7 analog source 5");

    // R9 R5 restart in mid-window ignored
    wr(A_BANK, 32'h0);
    wr(A_SRC, (32'd3 << 8) | 32'd1);
    wr(A_CTRL, 32'h0000_1000);
    wr(A_CTRL, 32'h0000_1010);
    rd(A_CTRL, v); chk(v == 32'h1010, "R5 busy after start", v, 32'h1010);
    repeat (500) @(posedge clk);
    wr(A_CTRL, 32'h0000_1010);
    repeat (585) @(posedge clk);
    rd(A_CTRL, v); chk(v[4] == 1'b0, "R9 original schedule kept", v[4], 0);
    exp_q.push_back(edges(8.0)); tol_q.push_back(2); tag_q.push_back("R9 count after ignored go");
    -> done_ev;
    @(ack_ev);

    // R8 saturation
    fast_on = 1'b1;
    wr(A_SRC, (32'd40 << 8) | 32'd1);
    measure(edges(0.25), 0, "R8 saturated count");
    fast_on = 1'b0;

    // R3 R10 R11 gated source hangs, then cancel
    rd(A_RES, kept);
    wr(A_SRC, 32'd3 << 8);
    wr(A_CTRL, 32'h0000_1000);
    wr(A_CTRL, 32'h0000_1010);
    repeat (3000) @(posedge clk);
    rd(A_CTRL, v); chk(v[4] == 1'b1, "R3 gated source never completes", v[4], 1);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk(v == 0, "R10 cancel clears control", v, 0);
    rd(A_RES, v);  chk(v == kept, "R11 result kept across cancel", v, kept);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule